// File: doc/BRIEF.md
# Column Polarity and Selective Charge-Share Controller

This controller sits beside the output stage of a display column driver. Each time a line is loaded, it samples an external polarity input and decides two things. The first is which reference half, high or low, the odd and the even columns are driven from. The second is whether the columns first pass through a charge-share phase, in which all columns are briefly tied together so that the stored charge moves them toward mid-range for free. Because polarity comes from outside, the controller handles dot inversion, column inversion and N-line inversion. Line inversion and frame inversion are not handled.

Sharing only pays off when the polarity of the columns actually reverses. The controller therefore compares the newly sampled polarity with the one stored at the previous load, and skips the shared phase when they match. On N-line inversion this avoids most of the sharing cycles. The first load after reset always shares.

The end of the shared window comes from one of two sources, picked by a mode input. In pulse mode the window closes when the load pulse goes low, so the load pulse width sets the window; a few hundred nanoseconds up to about a microsecond is typical. In RC mode the controller pulls an external timing node for one clock at the load edge and then releases it. The window closes once a digital threshold input reports that the node has decayed below half supply. Analog amplifiers and the resistor DACs are outside this block.

Top module: `colpol_share_ctrl`

## Requirements
- R1: During and after reset, before any load, share_o and all four drive outputs are 0, rc_release_o is 1, and pol_changed_o is 0.
- R2: While driving, polarity 0 latched at load gives odd_lo_o=1, even_hi_o=1, odd_hi_o=0, even_lo_o=0. Polarity 1 gives the reverse: odd_hi_o=1, even_lo_o=1, the others 0.
- R3: The first load rising edge after reset always starts a charge-share phase, even when the sampled polarity equals the reset value 0.
- R4: In pulse mode (rc_mode_i=0), share_o rises in the cycle after the clock edge that sees load_i rise. It falls, and the new polarity is driven, in the cycle after the first edge that sees load_i low. While share_o is 1, all four drive outputs are 0.
- R5: A load whose sampled polarity equals the stored polarity skips sharing. In the cycle after the load edge, share_o stays 0 and the drive outputs show the new line's polarity.
- R6: In RC mode (rc_mode_i=1), rc_release_o is 0 for exactly the one cycle after the edge that sees load_i rise, and 1 otherwise.
- R7: In RC mode, sharing ends in the cycle after the first edge at which rc_release_o is 1 and rc_thresh_i is 0. The falling edge of load_i has no effect on the window.
- R8: In RC mode, rc_thresh_i low is ignored while rc_release_o is 0, so sharing lasts at least two cycles.
- R9: pol_changed_o, updated at each load edge, is 1 when that load started a charge-share phase and 0 when it skipped one.
- R10: Changes on pol_i between load rising edges, and a held-high load_i, leave the drive outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Line load strobe; rising edge latches a line |
| pol_i | input | 1 | External polarity request, sampled at load rise |
| rc_mode_i | input | 1 | 0: window set by load pulse, 1: window set by RC threshold |
| rc_thresh_i | input | 1 | RC timing node still above half supply |
| rc_release_o | output | 1 | 0 while the RC node is pulled up, 1 once it is released |
| share_o | output | 1 | Columns tied to the common share node |
| odd_hi_o | output | 1 | Odd columns driven from high-polarity references |
| odd_lo_o | output | 1 | Odd columns driven from low-polarity references |
| even_hi_o | output | 1 | Even columns driven from high-polarity references |
| even_lo_o | output | 1 | Even columns driven from low-polarity references |
| pol_changed_o | output | 1 | Last load performed a charge share |

## Verification
The bench starts with a first load whose polarity equals the reset value. A design that compared polarities without a first-load flag would skip that share and drive straight away. It repeats one polarity across several loads, as N-line inversion does. Each repeat must go directly to driving, and a design that shared on every load would show share_o high there. In RC mode the threshold is dropped during the pull cycle and the load pulse ends early. A design that closed the window on either of these would end sharing one or more cycles too soon.

// File: rtl/colpol_pkg.sv
package colpol_pkg;

  typedef enum logic [1:0] {
    LS_IDLE  = 2'd0,
    LS_SHARE = 2'd1,
    LS_DRIVE = 2'd2
  } line_state_e;

  typedef struct packed {
    logic odd_hi;
    logic odd_lo;
    logic even_hi;
    logic even_lo;
  } col_drive_t;

  // Reference-half selection: polarity 0 puts odd columns on the low half.
  function automatic col_drive_t map_polarity(input logic pol, input logic enable);
    col_drive_t d;
    d.odd_hi  = enable &  pol;
    d.odd_lo  = enable & ~pol;
    d.even_hi = enable & ~pol;
    d.even_lo = enable &  pol;
    return d;
  endfunction

  // Sharing is worth doing only when the column polarity reverses.
  function automatic logic needs_share(input logic new_pol, input logic old_pol,
                                       input logic first_load);
    return first_load | (new_pol ^ old_pol);
  endfunction

endpackage

// File: rtl/colpol_edge_det.sv
module colpol_edge_det #(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= IDLE_LEVEL;
    else        sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/colpol_pol_track.sv
module colpol_pol_track
  import colpol_pkg::*;
#(
  parameter bit RESET_POL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic capture_i,
  input  logic pol_i,
  output logic line_pol_o,
  output logic share_req_o,
  output logic changed_o
);
  logic pol_q;
  logic first_q;
  logic changed_q;

  assign share_req_o = needs_share(pol_i, pol_q, first_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q     <= RESET_POL;
      first_q   <= 1'b1;
      changed_q <= 1'b0;
    end else if (capture_i) begin
      pol_q     <= pol_i;
      first_q   <= 1'b0;
      changed_q <= share_req_o;
    end
  end

  assign line_pol_o = pol_q;
  assign changed_o  = changed_q;
endmodule

// File: rtl/colpol_share_fsm.sv
module colpol_share_fsm
  import colpol_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_i,
  input  logic        share_req_i,
  input  logic        rc_mode_i,
  input  logic        load_i,
  input  logic        rc_thresh_i,
  output line_state_e state_o,
  output logic        release_o
);
  line_state_e state_q, state_d;
  logic        release_q;
  logic        window_done;

  // Pulse mode: window ends with load low. RC mode: node released and decayed.
  assign window_done = rc_mode_i ? (release_q & ~rc_thresh_i) : ~load_i;

  always_comb begin
    state_d = state_q;
    if (rise_i)
      state_d = share_req_i ? LS_SHARE : LS_DRIVE;
    else if (state_q == LS_SHARE && window_done)
      state_d = LS_DRIVE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= LS_IDLE;
      release_q <= 1'b1;
    end else begin
      state_q   <= state_d;
      release_q <= ~(rise_i & rc_mode_i);
    end
  end

  assign state_o   = state_q;
  assign release_o = release_q;
endmodule

// File: rtl/colpol_share_ctrl.sv
module colpol_share_ctrl
  import colpol_pkg::*;
#(
  parameter bit RESET_POL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic pol_i,
  input  logic rc_mode_i,
  input  logic rc_thresh_i,
  output logic rc_release_o,
  output logic share_o,
  output logic odd_hi_o,
  output logic odd_lo_o,
  output logic even_hi_o,
  output logic even_lo_o,
  output logic pol_changed_o
);
  logic        load_rise_w;
  logic        share_req_w;
  logic        line_pol_w;
  line_state_e line_state_w;
  col_drive_t  drive_w;

  colpol_edge_det #(.IDLE_LEVEL(1'b0)) u_load_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .sig_i (load_i),
    .rise_o(load_rise_w)
  );

  colpol_pol_track #(.RESET_POL(RESET_POL)) u_pol (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture_i  (load_rise_w),
    .pol_i      (pol_i),
    .line_pol_o (line_pol_w),
    .share_req_o(share_req_w),
    .changed_o  (pol_changed_o)
  );

  colpol_share_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_i     (load_rise_w),
    .share_req_i(share_req_w),
    .rc_mode_i  (rc_mode_i),
    .load_i     (load_i),
    .rc_thresh_i(rc_thresh_i),
    .state_o    (line_state_w),
    .release_o  (rc_release_o)
  );

  assign drive_w   = map_polarity(line_pol_w, line_state_w == LS_DRIVE);
  assign share_o   = (line_state_w == LS_SHARE);
  assign odd_hi_o  = drive_w.odd_hi;
  assign odd_lo_o  = drive_w.odd_lo;
  assign even_hi_o = drive_w.even_hi;
  assign even_lo_o = drive_w.even_lo;
endmodule

// File: rtl/colpol_share_ctrl_chk.sv
module colpol_share_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic rc_mode_i,
  input logic load_rise_w,
  input logic share_req_w,
  input logic rc_release_o,
  input logic share_o,
  input logic odd_hi_o,
  input logic odd_lo_o,
  input logic even_hi_o,
  input logic even_lo_o
);
  logic driving;
  assign driving = odd_hi_o | odd_lo_o | even_hi_o | even_lo_o;

  a_r4_share_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    share_o |-> !driving);

  a_r2_opposite_halves: assert property (@(posedge clk) disable iff (!rst_n)
    driving |-> (odd_hi_o != odd_lo_o) && (odd_hi_o == even_lo_o) && (odd_lo_o == even_hi_o));

  a_r6_pull_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise_w && rc_mode_i) |=> !rc_release_o);

  a_r6_release_after_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!rc_release_o && !(load_rise_w && rc_mode_i)) |=> rc_release_o);

  a_r5_skip_share: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise_w && !share_req_w) |=> (!share_o && driving));

  a_r10_hold_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (driving && !load_rise_w) |=> ($stable(odd_hi_o) && $stable(odd_lo_o)));
endmodule

bind colpol_share_ctrl colpol_share_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rc_mode_i   (rc_mode_i),
  .load_rise_w (load_rise_w),
  .share_req_w (share_req_w),
  .rc_release_o(rc_release_o),
  .share_o     (share_o),
  .odd_hi_o    (odd_hi_o),
  .odd_lo_o    (odd_lo_o),
  .even_hi_o   (even_hi_o),
  .even_lo_o   (even_lo_o)
);

// File: tb/test_colpol_share_ctrl.sv
`timescale 1ns/1ps
module test_colpol_share_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_i = 1'b0, pol_i = 1'b0, rc_mode_i = 1'b0, rc_thresh_i = 1'b0;
  logic rc_release_o, share_o, odd_hi_o, odd_lo_o, even_hi_o, even_lo_o, pol_changed_o;

  always #2.5 clk = ~clk;

  colpol_share_ctrl i_colpol_share_ctrl (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .pol_i(pol_i),
    .rc_mode_i(rc_mode_i), .rc_thresh_i(rc_thresh_i),
    .rc_release_o(rc_release_o), .share_o(share_o),
    .odd_hi_o(odd_hi_o), .odd_lo_o(odd_lo_o),
    .even_hi_o(even_hi_o), .even_lo_o(even_lo_o),
    .pol_changed_o(pol_changed_o)
  );

  // Expected vector: {share, odd_hi, odd_lo, even_hi, even_lo, release, changed}
  typedef struct {
    logic [6:0] exp;
    logic [6:0] mask;
    string      req;
  } exp_item_t;

  exp_item_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [3:0] BLANK = 4'b0000;
  localparam logic [3:0] POL0  = 4'b0110;  // odd low half, even high half
  localparam logic [3:0] POL1  = 4'b1001;  // odd high half, even low half

  function automatic logic [6:0] vec(input logic sh, input logic [3:0] d,
                                     input logic rel, input logic chg);
    return {sh, d, rel, chg};
  endfunction

  // Driver: apply inputs at negedge, push the outputs expected after the next edge.
  task automatic step(input logic ld, input logic pl, input logic md, input logic th,
                      input logic [6:0] e, input logic [6:0] m, input string r);
    exp_item_t it;
    @(negedge clk);
    load_i = ld; pol_i = pl; rc_mode_i = md; rc_thresh_i = th;
    it.exp = e; it.mask = m; it.req = r;
    sb_q.push_back(it);
  endtask

  // Monitor: sample shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_item_t it;
        logic [6:0] act;
        it  = sb_q.pop_front();
        act = {share_o, odd_hi_o, odd_lo_o, even_hi_o, even_lo_o, rc_release_o, pol_changed_o};
        checks++;
        if ((act & it.mask) !== (it.exp & it.mask)) begin
          errors++;
          $display("FAIL %s: actual %b expected %b (mask %b)", it.req, act, it.exp, it.mask);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  localparam logic [6:0] ALL = 7'h7F;

  initial begin
    // R1: reset values, held in reset and just after
    step(0, 0, 0, 0, vec(0, BLANK, 1, 0), ALL, "R1 in reset");
    step(0, 0, 0, 0, vec(0, BLANK, 1, 0), ALL, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, vec(0, BLANK, 1, 0), ALL, "R1 after reset");

    // Pulse mode. R3: first load shares although pol equals reset value
    step(1, 0, 0, 0, vec(1, BLANK, 1, 1), ALL, "R3 first load shares");
    step(1, 0, 0, 0, vec(1, BLANK, 1, 1), ALL, "R4 share held while load high");
    step(0, 0, 0, 0, vec(0, POL0, 1, 1), ALL, "R4 R2 load fall ends share, pol0 map");
    step(0, 1, 0, 0, vec(0, POL0, 1, 1), ALL, "R10 pol change between loads ignored");
    step(1, 1, 0, 0, vec(1, BLANK, 1, 1), ALL, "R9 polarity flip shares");
    step(0, 1, 0, 0, vec(0, POL1, 1, 1), ALL, "R2 pol1 map");
    step(1, 1, 0, 0, vec(0, POL1, 1, 0), ALL, "R5 same polarity skips share");
    step(1, 0, 0, 0, vec(0, POL1, 1, 0), ALL, "R10 held load ignores pol");
    step(0, 0, 0, 0, vec(0, POL1, 1, 0), ALL, "R10 hold");
    step(1, 1, 0, 0, vec(0, POL1, 1, 0), ALL, "R5 N-line repeat skips share");
    step(0, 1, 0, 0, vec(0, POL1, 1, 0), ALL, "R9 changed flag stays 0");

    // RC mode
    step(1, 0, 1, 1, vec(1, BLANK, 0, 1), ALL, "R6 pull cycle, share starts");
    step(0, 0, 1, 0, vec(1, BLANK, 1, 1), ALL, "R8 R7 thresh low while pulled and load fall ignored");
    step(0, 0, 1, 1, vec(1, BLANK, 1, 1), ALL, "R7 share holds while node above threshold");
    step(0, 0, 1, 1, vec(1, BLANK, 1, 1), ALL, "R7 share still holds");
    step(0, 0, 1, 0, vec(0, POL0, 1, 1), ALL, "R7 threshold drop ends share");
    step(1, 0, 1, 1, vec(0, POL0, 0, 0), ALL, "R5 R6 RC load without flip");
    step(1, 0, 1, 1, vec(0, POL0, 1, 0), ALL, "R6 release after one cycle");
    step(0, 1, 1, 1, vec(0, POL0, 1, 0), ALL, "R10 hold in RC mode");
    step(1, 1, 1, 1, vec(1, BLANK, 0, 1), ALL, "R9 RC flip shares");
    step(0, 1, 1, 0, vec(1, BLANK, 1, 1), ALL, "R8 minimum two share cycles");
    step(0, 1, 1, 0, vec(0, POL1, 1, 1), ALL, "R7 ends after release");

    // Second reset: R3 again for the first load after it
    @(negedge clk); rst_n = 1'b0;
    step(0, 0, 0, 0, vec(0, BLANK, 1, 0), ALL, "R1 reset again");
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 0, 0, vec(1, BLANK, 1, 1), ALL, "R3 first load after second reset");
    step(0, 0, 0, 0, vec(0, POL0, 1, 1), ALL, "R4 R2 end of share");

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule